// File: doc/BRIEF.md
# SECDED-Protected Synchronous FIFO

This block is a single-clock FIFO whose storage words are each guarded by a Hamming single-error-correct, double-error-detect code. A 32-bit payload is stored as a 39-bit codeword: 6 Hamming check bits at the power-of-two positions 1, 2, 4, 8, 16 and 32, the data bits in order at the remaining positions 3, 5, 6, 7, 9, ..., 38, and an overall parity bit at position 0. The head of the queue is presented on the read port at all times (first-word-fall-through). When checking is active, a read corrects a single flipped bit and flags it. A double flip is flagged as uncorrectable and the stored data is passed through unchanged.

After reset the block clears its whole array with all-zero codewords, one location per cycle, and refuses traffic until that sweep ends. Checking follows the enable input only once the sweep is complete. A test port arms a one-shot fault for the next accepted write: either data bit 0 alone is flipped, or data bits 0 and 1 are both flipped. Popping a flagged word sets one of two sticky interrupt lines. Each line is cleared by its own write-one-to-clear input.

Top module: `secded_fifo`

## Requirements
- R1: From reset release, the block spends DEPTH cycles clearing the array. During reset and during the sweep, init_done_o is 0 and both full_o and empty_o are 1, and no push is accepted. After exactly DEPTH rising edges, init_done_o is 1 and the queue is empty.
- R2: ecc_on_o equals ecc_en_i AND init_done_o. Before the sweep completes, ecc_en_i has no effect.
- R3: Words leave in the order they were accepted. While empty_o is 0, rd_data_o shows the oldest word, and rd_valid_i removes it at the next edge.
- R4: full_o rises when DEPTH words are held. A push while full, or a pop while empty, changes neither the contents nor the flags. A simultaneous push and pop on a non-empty, non-full queue keeps the count unchanged.
- R5: A pulse on inj_arm_i with inj_dbl_i=0 arms a fault that flips data bit 0 of the next accepted write only. The arm is consumed by that write. An arm pulse in the same cycle as a write applies to the following write.
- R6: With inj_dbl_i=1, the armed fault flips data bits 0 and 1 of the next accepted write.
- R7: With ecc_on_o=1, a head word with one flipped bit is shown corrected, with rd_sbe_o=1. A head word with two flipped bits is shown as stored (uncorrected), with rd_dbe_o=1.
- R8: With ecc_on_o=0, rd_data_o shows the stored data bits as they are, and rd_sbe_o and rd_dbe_o stay 0.
- R9: sbe_irq_o / dbe_irq_o go to 1 on the edge after a pop of a word flagged by rd_sbe_o / rd_dbe_o. They then stay 1 until the edge at which sbe_clr_i / dbe_clr_i is 1. A new event in the same cycle as a clear leaves the line set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Push request |
| wr_data_i | input | 32 | Push data |
| full_o | output | 1 | Queue full or sweep in progress |
| rd_valid_i | input | 1 | Pop request |
| rd_data_o | output | 32 | Head word, corrected when checking is on |
| empty_o | output | 1 | Queue empty or sweep in progress |
| ecc_en_i | input | 1 | Checking enable |
| ecc_on_o | output | 1 | Checking actually active |
| init_done_o | output | 1 | Clearing sweep finished |
| inj_arm_i | input | 1 | Arm a one-shot fault for the next write |
| inj_dbl_i | input | 1 | Fault kind at arming: 0 one bit, 1 two bits |
| rd_sbe_o | output | 1 | Head word had a corrected single error |
| rd_dbe_o | output | 1 | Head word had an uncorrectable double error |
| sbe_irq_o | output | 1 | Sticky corrected-error interrupt |
| dbe_irq_o | output | 1 | Sticky uncorrectable-error interrupt |
| sbe_clr_i | input | 1 | Clear sbe_irq_o |
| dbe_clr_i | input | 1 | Clear dbe_irq_o |

## Verification
A corrupted pointer or count shows up within one cycle as a wrong head word on rd_data_o, or as a wrong full_o or empty_o. A wrong codeword layout or syndrome decode shows up on the first pop of an injected word, as a wrong data value or a wrong flag. Clean words may also be misread in the same way. A stuck or lost injection arm shows up as a flag on the wrong word. Interrupt state faults appear one edge after the pop or clear that should have moved them.

// File: rtl/secded_fifo_pkg.sv
package secded_fifo_pkg;
  localparam int DATA_W = 32;
  localparam int HAM_W  = 6;
  localparam int CODE_W = DATA_W + HAM_W + 1;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef enum logic [1:0] {INJ_NONE = 2'd0, INJ_ONE = 2'd1, INJ_TWO = 2'd2} inj_e;

  function automatic bit is_pow2(input int v);
    return (v & (v - 1)) == 0;
  endfunction

  // codeword position of data bit i (non-power-of-two slots, ascending)
  function automatic int data_pos(input int i);
    int k;
    int r;
    k = -1;
    r = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!is_pow2(p)) begin
        k = k + 1;
        if (k == i) r = p;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_fifo_pkg::*;
(
  input  data_t data_i,
  input  inj_e  flip_i,
  output code_t code_o
);
  code_t c;
  logic  par;

  always_comb begin
    c   = '0;
    par = 1'b0;
    for (int i = 0; i < DATA_W; i++) c[data_pos(i)] = data_i[i];
    for (int p = 0; p < HAM_W; p++) begin
      par = 1'b0;
      for (int q = 1; q < CODE_W; q++)
        if (((q >> p) & 1) == 1) par = par ^ c[q];
      c[1 << p] = par;
    end
    c[0] = ^c[CODE_W-1:1];
    // test faults land on stored data bits after encoding
    if (flip_i != INJ_NONE) c[data_pos(0)] = ~c[data_pos(0)];
    if (flip_i == INJ_TWO)  c[data_pos(1)] = ~c[data_pos(1)];
  end

  assign code_o = c;
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_fifo_pkg::*;
(
  input  code_t code_i,
  input  logic  fix_en_i,
  output data_t data_o,
  output logic  sbe_o,
  output logic  dbe_o
);
  logic [HAM_W-1:0] syn;
  logic             ovr;
  code_t            fixed;

  always_comb begin
    syn = '0;
    for (int p = 0; p < HAM_W; p++)
      for (int q = 1; q < CODE_W; q++)
        if (((q >> p) & 1) == 1) syn[p] = syn[p] ^ code_i[q];
    ovr   = ^code_i;
    sbe_o = ovr;
    dbe_o = !ovr && (syn != '0);
    fixed = code_i;
    // syn==0 with odd parity means the parity bit itself flipped
    if (fix_en_i && ovr && (int'(syn) < CODE_W))
      fixed[int'(syn)] = ~fixed[int'(syn)];
    for (int i = 0; i < DATA_W; i++) data_o[i] = fixed[data_pos(i)];
  end
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
  parameter int W     = 39,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  output logic          wr_acc_o,
  output logic          rd_acc_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic          init_busy_o,
  output logic [AW-1:0] init_addr_o,
  output logic          init_done_o
);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [AW-1:0] wr_q, rd_q, ini_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign full_o   = !done_q || (cnt_q == FULLC);
  assign empty_o  = !done_q || (cnt_q == '0);
  assign wr_acc_o = wr_req_i && !full_o;
  assign rd_acc_o = rd_req_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ini_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (ini_q == LAST) done_q <= 1'b1;
      else               ini_q  <= ini_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_acc_o) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (rd_acc_o) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (wr_acc_o && !rd_acc_o)      cnt_q <= cnt_q + 1'b1;
      else if (!wr_acc_o && rd_acc_o) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign wr_ptr_o    = wr_q;
  assign rd_ptr_o    = rd_q;
  assign init_busy_o = !done_q;
  assign init_addr_o = ini_q;
  assign init_done_o = done_q;

  // R4
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULLC);
  // R4
  no_push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_req_i && !rd_req_i) |=> ($stable(wr_q) && $stable(cnt_q)));
  // R4
  no_pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_req_i && !wr_req_i) |=> ($stable(rd_q) && $stable(cnt_q)));
  // R1
  init_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> (cnt_q == '0 && wr_q == '0 && rd_q == '0));
endmodule

// File: rtl/secded_fifo.sv
module secded_fifo
  import secded_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_o,
  input  logic              rd_valid_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  input  logic              ecc_en_i,
  output logic              ecc_on_o,
  output logic              init_done_o,
  input  logic              inj_arm_i,
  input  logic              inj_dbl_i,
  output logic              rd_sbe_o,
  output logic              rd_dbe_o,
  output logic              sbe_irq_o,
  output logic              dbe_irq_o,
  input  logic              sbe_clr_i,
  input  logic              dbe_clr_i
);
  logic          wr_acc, rd_acc, init_busy;
  logic [AW-1:0] wr_ptr, rd_ptr, init_addr;
  logic          we;
  logic [AW-1:0] waddr;
  code_t         enc_code, wcode, rcode;
  inj_e          inj_q;
  logic          raw_sbe, raw_dbe;
  logic          sbe_q, dbe_q;

  fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_req_i    (wr_valid_i),
    .rd_req_i    (rd_valid_i),
    .wr_acc_o    (wr_acc),
    .rd_acc_o    (rd_acc),
    .full_o      (full_o),
    .empty_o     (empty_o),
    .wr_ptr_o    (wr_ptr),
    .rd_ptr_o    (rd_ptr),
    .init_busy_o (init_busy),
    .init_addr_o (init_addr),
    .init_done_o (init_done_o)
  );

  secded_enc u_enc (
    .data_i (wr_data_i),
    .flip_i (inj_q),
    .code_o (enc_code)
  );

  // all-zero is a valid codeword, so the sweep needs no encoder
  assign we    = init_busy || wr_acc;
  assign waddr = init_busy ? init_addr : wr_ptr;
  assign wcode = init_busy ? '0 : enc_code;

  fifo_mem #(.W(CODE_W), .DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wcode),
    .raddr_i (rd_ptr),
    .rdata_o (rcode)
  );

  assign ecc_on_o = ecc_en_i && init_done_o;

  secded_dec u_dec (
    .code_i   (rcode),
    .fix_en_i (ecc_on_o),
    .data_o   (rd_data_o),
    .sbe_o    (raw_sbe),
    .dbe_o    (raw_dbe)
  );

  assign rd_sbe_o = ecc_on_o && !empty_o && raw_sbe;
  assign rd_dbe_o = ecc_on_o && !empty_o && raw_dbe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        inj_q <= INJ_NONE;
    else if (inj_arm_i) inj_q <= inj_dbl_i ? INJ_TWO : INJ_ONE;
    else if (wr_acc)    inj_q <= INJ_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sbe_q <= 1'b0;
      dbe_q <= 1'b0;
    end else begin
      sbe_q <= (rd_acc && rd_sbe_o) || (sbe_q && !sbe_clr_i);
      dbe_q <= (rd_acc && rd_dbe_o) || (dbe_q && !dbe_clr_i);
    end
  end

  assign sbe_irq_o = sbe_q;
  assign dbe_irq_o = dbe_q;

  // R2
  ecc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_on_o |-> init_done_o);
  // R5
  arm_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_q != INJ_NONE && wr_acc && !inj_arm_i) |=> (inj_q == INJ_NONE));
  // R9
  sbe_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_sbe_o) |=> sbe_irq_o);
  // R9
  dbe_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_dbe_o) |=> dbe_irq_o);
  // R9
  sbe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbe_irq_o && !sbe_clr_i) |=> sbe_irq_o);
  // R9
  dbe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbe_irq_o && !dbe_clr_i) |=> dbe_irq_o);
  // R7
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_sbe_o && rd_dbe_o));
endmodule

// File: tb/secded_fifo_tb_top.sv
module secded_fifo_tb_top;
  localparam int DEPTH = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0, rd_valid_i = 1'b0, ecc_en_i = 1'b0;
  logic        inj_arm_i = 1'b0, inj_dbl_i = 1'b0, sbe_clr_i = 1'b0, dbe_clr_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        full_o, empty_o, ecc_on_o, init_done_o, rd_sbe_o, rd_dbe_o, sbe_irq_o, dbe_irq_o;
  logic [31:0] rd_data_o;

  always #4 clk_i = ~clk_i;

  secded_fifo #(.DEPTH(DEPTH)) dut_i (.*);

  int checks = 0, fails = 0;
  logic [31:0] q_data [$];
  int          q_mode [$];
  int m_cnt = 0, m_arm = 0;
  bit m_sirq = 0, m_dirq = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one clock: check outputs against model, take the edge, advance model
  task automatic cyc();
    bit done, full, empty, act, push, pop, es, ed;
    logic [31:0] raw, ed_data;
    int mode;
    done  = (m_cnt >= DEPTH);
    full  = !done || (q_data.size() == DEPTH);
    empty = !done || (q_data.size() == 0);
    act   = ecc_en_i && done;
    es = 0; ed = 0; ed_data = '0; mode = 0;
    if (!empty) begin
      mode = q_mode[0];
      raw  = q_data[0] ^ ((mode == 1) ? 32'h1 : (mode == 2) ? 32'h3 : 32'h0);
      es   = act && mode == 1;
      ed   = act && mode == 2;
      ed_data = (act && mode == 1) ? q_data[0] : raw;
    end
    #1;
    chk("R1", "init_done", {31'd0, init_done_o}, {31'd0, done});
    chk("R4", "full", {31'd0, full_o}, {31'd0, full});
    chk("R4", "empty", {31'd0, empty_o}, {31'd0, empty});
    chk("R2", "ecc_on", {31'd0, ecc_on_o}, {31'd0, act});
    chk("R7", "rd_sbe", {31'd0, rd_sbe_o}, {31'd0, es});
    chk("R7", "rd_dbe", {31'd0, rd_dbe_o}, {31'd0, ed});
    chk("R9", "sbe_irq", {31'd0, sbe_irq_o}, {31'd0, m_sirq});
    chk("R9", "dbe_irq", {31'd0, dbe_irq_o}, {31'd0, m_dirq});
    if (!empty) begin
      if (mode == 0)      chk("R3", "rd_data", rd_data_o, ed_data);
      else if (!act)      chk("R8", "rd_data", rd_data_o, ed_data);
      else if (mode == 1) chk("R5", "rd_data", rd_data_o, ed_data);
      else                chk("R6", "rd_data", rd_data_o, ed_data);
    end
    pop  = rd_valid_i && !empty;
    push = wr_valid_i && !full;
    @(posedge clk_i);
    m_sirq = (pop && es) || (m_sirq && !sbe_clr_i);
    m_dirq = (pop && ed) || (m_dirq && !dbe_clr_i);
    if (pop) begin void'(q_data.pop_front()); void'(q_mode.pop_front()); end
    if (push) begin q_data.push_back(wr_data_i); q_mode.push_back(m_arm); end
    if (inj_arm_i) m_arm = inj_dbl_i ? 2 : 1;
    else if (push) m_arm = 0;
    if (m_cnt < DEPTH) m_cnt++;
    @(negedge clk_i);
    wr_valid_i = 0; rd_valid_i = 0; inj_arm_i = 0; inj_dbl_i = 0;
    sbe_clr_i = 0; dbe_clr_i = 0;
  endtask

  task automatic push(input logic [31:0] d);
    wr_valid_i = 1; wr_data_i = d; cyc();
  endtask
  task automatic pop();
    rd_valid_i = 1; cyc();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    ecc_en_i = 1;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "reset init_done", {31'd0, init_done_o}, 32'd0);
    chk("R1", "reset full", {31'd0, full_o}, 32'd1);
    chk("R1", "reset empty", {31'd0, empty_o}, 32'd1);
    chk("R9", "reset irqs", {30'd0, sbe_irq_o, dbe_irq_o}, 32'd0);
    rst_ni = 1;
    // R1/R2 sweep: pushes refused, enable ignored
    for (int i = 0; i < DEPTH; i++) push(32'hDEAD_0000 + i);
    cyc();
    // R3 ordering
    for (int i = 0; i < 5; i++) push(32'h1234_5670 + i * 32'h0101_0101);
    for (int i = 0; i < 5; i++) pop();
    // R4 overflow and underflow
    for (int i = 0; i < DEPTH + 2; i++) push(32'hA5A5_0000 ^ (i << 4));
    wr_valid_i = 1; rd_valid_i = 1; wr_data_i = 32'h0BAD_BEEF; cyc();  // full: pop only
    for (int i = 0; i < DEPTH + 2; i++) pop();
    wr_valid_i = 1; rd_valid_i = 1; wr_data_i = 32'hCAFE_0001; cyc();  // empty: push only
    wr_valid_i = 1; rd_valid_i = 1; wr_data_i = 32'hCAFE_0002; cyc();  // both
    pop();
    // R5 single inject, arm consumed
    inj_arm_i = 1; cyc();
    push(32'hFFFF_FFFF);
    push(32'h0000_00F0);
    pop(); pop();
    cyc();
    sbe_clr_i = 1; cyc();
    // R5 arm in same cycle as write applies to the next write
    inj_arm_i = 1; push(32'h7777_0000);
    push(32'h7777_0001);
    pop(); pop();
    // R6/R7 double inject
    inj_arm_i = 1; inj_dbl_i = 1; cyc();
    push(32'h8000_0002);
    pop();
    cyc();
    // R9 set wins over clear
    inj_arm_i = 1; cyc();
    push(32'h0000_0003);
    rd_valid_i = 1; sbe_clr_i = 1; cyc();
    dbe_clr_i = 1; cyc();
    sbe_clr_i = 1; cyc();
    // R8 checking off: raw data, no flags
    ecc_en_i = 0;
    inj_arm_i = 1; cyc();
    push(32'h5555_AAAA);
    inj_arm_i = 1; inj_dbl_i = 1; cyc();
    push(32'h1357_9BDF);
    pop(); pop();
    ecc_en_i = 1;
    cyc();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule